// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This controller turns single host requests into the strobe sequences of an asynchronous-style DRAM device whose row and column addresses share one set of address pins. A request carries a full address, a write flag, write data and an access mode. The controller splits the address into a row part (upper bits) and a column part (lower bits). It presents the row with the row strobe, waits a programmable row-to-column delay, then presents the column with the column strobe for a programmable column-access time.

Three access modes are offered. A basic access opens a row, touches one column and closes the row. A burst access is given only its first column and generates four consecutive columns with an internal counter. A page access leaves the row open so that later page requests to the same row skip the row phase. Data moves on one bidirectional bus that the controller drives only while writing. A separate request/grant/done handshake lets a refresh engine take the device while the controller is idle with the row strobe released, and every row activation is preceded by a programmable precharge interval.

Top module: `dram_mux_ctrl`

## Requirements
- R1: At each falling edge of `dram_ras_n` the address bus carries the row (`req_addr[ROW_W+COL_W-1:COL_W]`); at each falling edge of `dram_cas_n` it carries the column (`req_addr[COL_W-1:0]`, or the burst-generated column). `dram_cas_n` is low only while `dram_ras_n` is low.
- R2: `dram_cas_n` first falls exactly T_RCD cycles after `dram_ras_n` falls, and each column cycle keeps `dram_cas_n` low for exactly T_CAS cycles.
- R3: Mode 2'b00 (basic; 2'b11 behaves the same) performs one row activation and one column cycle, then releases `dram_ras_n`.
- R4: Mode 2'b01 (burst) performs four column cycles under one activation; beat k uses the supplied column with its low two bits plus k modulo 4, the upper column bits and the row unchanged; a burst write stores `req_wdata + k` in beat k.
- R5: Mode 2'b10 (page) leaves the row open after its column cycle; a following page request to the same row issues a column cycle with no new activation, and any other request closes the row and activates again.
- R6: The controller drives `dram_dq` only during write column cycles (with `dram_we_n` low, only while `dram_cas_n` is low) and leaves it at high impedance otherwise, so read data from the device arrives intact.
- R7: Each read column cycle yields one `rd_valid` pulse, in the cycle after `dram_cas_n` rises, carrying the bus value sampled in the last strobe cycle; a burst read yields four pulses in column order, a write none.
- R8: `ref_gnt` is raised only while `dram_ras_n` and `dram_cas_n` are high, stays high until `ref_done`, falls in the cycle after `ref_done`, and no host request is accepted while it is high; an open page is closed when `ref_req` arrives.
- R9: `dram_ras_n` stays high at least T_RP cycles before every activation, including after a page close and after a refresh.
- R10: After reset `dram_ras_n`, `dram_cas_n`, `dram_we_n` are high, `ref_gnt` and `rd_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 00 basic, 01 burst, 10 page, 11 basic |
| req_addr | input | ROW_W+COL_W | Full address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One pulse per returned read word |
| rd_data | output | DATA_W | Read word |
| ref_req | input | 1 | Refresh engine asks for the device |
| ref_gnt | output | 1 | Device handed to refresh engine |
| ref_done | input | 1 | Refresh engine finished |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq | inout | DATA_W | Bidirectional data bus |

## Verification
A vector table drives writes then reads in each mode against a behavioural device, so stored data, column sequence, strobe counts and activation counts separate a missing row phase from a wrong column order. Burst accesses start at a column whose low bits are 2, which makes the modulo-4 wrap visible, and a read of the next row shows that the wrap did not carry. Page requests alternate between a hit and a miss so an extra activation or a missing close shows up in the activation count, and a refresh arriving with a page open checks the close, the grant hold and the blocked host port.

// File: rtl/dram_mux_pkg.sv
// Shared encodings for the multiplexed-address DRAM controller.
package dram_mux_pkg;
    typedef enum logic [1:0] {
        MODE_BASIC = 2'b00,
        MODE_BURST = 2'b01,
        MODE_PAGE  = 2'b10,
        MODE_ALT   = 2'b11
    } acc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACT, ST_CAS, ST_GAP, ST_OPEN, ST_PRE, ST_REF
    } seq_state_e;

    localparam int BURST_LEN = 4;
    localparam int BURST_OFS_W = 2;
endpackage

// File: rtl/dram_mux_timer.sv
// Down-counter used for every strobe interval.
// Assumes load values are the wanted cycle count minus one; zero flags expiry.
module dram_mux_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    // Load or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dram_mux_colgen.sv
// Column register; burst steps wrap inside the low OFS_W bits only.
// Assumes COL_W >= OFS_W.
module dram_mux_colgen #(
    parameter int COL_W = 4,
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [COL_W-1:0] load_col,
    input  logic             inc,
    output logic [COL_W-1:0] col
);
    // Capture a new column or step its low offset.
    always_ff @(posedge clk) begin
        if (!rst_n)     col <= '0;
        else if (load)  col <= load_col;
        else if (inc)   col[OFS_W-1:0] <= col[OFS_W-1:0] + OFS_W'(1);
    end
endmodule

// File: rtl/dram_mux_seq.sv
// Access sequencer: activation, column cycles, page hold, precharge, refresh.
// Assumes every timing parameter is at least 1 and fits in CW bits when reduced by one.
module dram_mux_seq
    import dram_mux_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int DATA_W = 8,
    parameter int T_RCD  = 3,
    parameter int T_CAS  = 2,
    parameter int T_RP   = 2,
    parameter int CW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ref_req,
    input  logic              ref_done,
    input  logic              t_zero,
    output logic              req_ready,
    output logic              ref_gnt,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              sel_row,
    output logic              t_load,
    output logic [CW-1:0]     t_val,
    output logic              col_load,
    output logic              col_inc,
    output logic [ROW_W-1:0]  row_q,
    output logic [DATA_W-1:0] wdata_out,
    output logic              dq_oe,
    output logic              rd_strobe
);
    seq_state_e        state, state_d;
    logic              wr_q, pend, pend_set, pend_clr;
    logic [1:0]        mode_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        beat;
    logic              beat_clr, beat_inc, acc, page_hit;

    assign req_ready = !ref_req && (state == ST_IDLE || state == ST_OPEN);
    assign acc       = req_valid && req_ready;
    assign page_hit  = (req_mode == MODE_PAGE) && (req_row == row_q);
    assign col_load  = acc;

    // Next-state choice and timer/column/beat controls.
    always_comb begin
        state_d  = state;
        t_load   = 1'b0;
        t_val    = '0;
        col_inc  = 1'b0;
        beat_clr = 1'b0;
        beat_inc = 1'b0;
        pend_set = 1'b0;
        pend_clr = 1'b0;
        case (state)
            ST_IDLE: begin
                if (ref_req) state_d = ST_REF;
                else if (req_valid) begin
                    state_d = ST_ACT; t_load = 1'b1; t_val = CW'(T_RCD - 1);
                end
            end
            ST_ACT: if (t_zero) begin
                state_d = ST_CAS; t_load = 1'b1; t_val = CW'(T_CAS - 1); beat_clr = 1'b1;
            end
            ST_CAS: if (t_zero) state_d = ST_GAP;
            ST_GAP: begin
                if (mode_q == MODE_BURST && beat != 2'(BURST_LEN - 1)) begin
                    state_d = ST_CAS; t_load = 1'b1; t_val = CW'(T_CAS - 1);
                    col_inc = 1'b1; beat_inc = 1'b1;
                end else if (mode_q == MODE_PAGE) begin
                    state_d = ST_OPEN;
                end else begin
                    state_d = ST_PRE; t_load = 1'b1; t_val = CW'(T_RP - 1); pend_clr = 1'b1;
                end
            end
            ST_OPEN: begin
                if (ref_req) begin
                    state_d = ST_PRE; t_load = 1'b1; t_val = CW'(T_RP - 1); pend_clr = 1'b1;
                end else if (req_valid && page_hit) begin
                    state_d = ST_CAS; t_load = 1'b1; t_val = CW'(T_CAS - 1); beat_clr = 1'b1;
                end else if (req_valid) begin
                    state_d = ST_PRE; t_load = 1'b1; t_val = CW'(T_RP - 1); pend_set = 1'b1;
                end
            end
            ST_PRE: if (t_zero) begin
                if (pend) begin
                    state_d = ST_ACT; t_load = 1'b1; t_val = CW'(T_RCD - 1); pend_clr = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_REF: if (ref_done) begin
                state_d = ST_PRE; t_load = 1'b1; t_val = CW'(T_RP - 1); pend_clr = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, pending-activation flag and beat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pend  <= 1'b0;
            beat  <= '0;
        end else begin
            state <= state_d;
            if (pend_set)      pend <= 1'b1;
            else if (pend_clr) pend <= 1'b0;
            if (beat_clr)      beat <= '0;
            else if (beat_inc) beat <= beat + 2'd1;
        end
    end

    // Request fields held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0; wr_q <= 1'b0; mode_q <= MODE_BASIC; wdata_q <= '0;
        end else if (acc) begin
            row_q <= req_row; wr_q <= req_write; mode_q <= req_mode; wdata_q <= req_wdata;
        end
    end

    assign ras_n     = !(state == ST_ACT || state == ST_CAS || state == ST_GAP || state == ST_OPEN);
    assign cas_n     = (state != ST_CAS);
    assign we_n      = !(state == ST_CAS && wr_q);
    assign dq_oe     = (state == ST_CAS) && wr_q;
    assign sel_row   = (state == ST_ACT);
    assign ref_gnt   = (state == ST_REF);
    assign rd_strobe = (state == ST_CAS) && t_zero && !wr_q;
    assign wdata_out = wdata_q + DATA_W'(beat);
endmodule

// File: rtl/dram_mux_ctrl.sv
// Top: splits the host address, drives the shared address and data buses,
// captures read words. Assumes the device presents read data while its
// column strobe is low with write enable high.
module dram_mux_ctrl
    import dram_mux_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8,
    parameter int T_RCD  = 3,
    parameter int T_CAS  = 2,
    parameter int T_RP   = 2,
    localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int TMAX  = (T_RCD > T_CAS) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                           : ((T_CAS > T_RP) ? T_CAS : T_RP),
    localparam int CW    = (TMAX > 1) ? $clog2(TMAX) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [1:0]             req_mode,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data,
    input  logic                   ref_req,
    output logic                   ref_gnt,
    input  logic                   ref_done,
    output logic [AW-1:0]          dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    inout  wire  [DATA_W-1:0]      dram_dq
);
    logic              t_zero, t_load, col_load, col_inc, sel_row, dq_oe, rd_strobe;
    logic [CW-1:0]     t_val;
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row_q;
    logic [DATA_W-1:0] wdata_out;

    dram_mux_seq #(
        .ROW_W(ROW_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .CW(CW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mode(req_mode), .req_row(req_addr[ROW_W+COL_W-1:COL_W]), .req_wdata(req_wdata),
        .ref_req(ref_req), .ref_done(ref_done), .t_zero(t_zero), .req_ready(req_ready),
        .ref_gnt(ref_gnt), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
        .sel_row(sel_row), .t_load(t_load), .t_val(t_val), .col_load(col_load),
        .col_inc(col_inc), .row_q(row_q), .wdata_out(wdata_out), .dq_oe(dq_oe),
        .rd_strobe(rd_strobe)
    );

    dram_mux_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    dram_mux_colgen #(.COL_W(COL_W), .OFS_W(BURST_OFS_W)) u_col (
        .clk(clk), .rst_n(rst_n), .load(col_load), .load_col(req_addr[COL_W-1:0]),
        .inc(col_inc), .col(col)
    );

    assign dram_addr = sel_row ? AW'(row_q) : AW'(col);
    assign dram_dq   = dq_oe ? wdata_out : {DATA_W{1'bz}};

    // Capture the read word at the end of its column cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_strobe;
            if (rd_strobe) rd_data <= dram_dq;
        end
    end
endmodule

// File: rtl/dram_mux_ctrl_chk.sv
// Protocol checker bound to the controller top; observes its ports only.
module dram_mux_ctrl_chk #(
    parameter int T_RCD = 3,
    parameter int T_RP  = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ref_gnt,
    input logic ref_done,
    input logic req_ready,
    input logic rd_valid
);
    logic [7:0] hi_cnt, lo_cnt;

    // Length of the current run of row strobe high / low cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= 8'(T_RP);
            lo_cnt <= '0;
        end else if (ras_n) begin
            hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= '0;
            lo_cnt <= (lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1;
        end
    end

    assert_cas_in_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    assert_rcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> lo_cnt >= 8'(T_RCD));
    assert_we_in_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cas_n);
    assert_rd_after_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> cas_n && $past(!cas_n && we_n));
    assert_gnt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> ras_n && cas_n && !req_ready);
    assert_gnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt && !ref_done |=> ref_gnt);
    assert_precharge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> hi_cnt >= 8'(T_RP));
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.T_RCD(T_RCD), .T_RP(T_RP)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .ref_gnt(ref_gnt), .ref_done(ref_done), .req_ready(req_ready), .rd_valid(rd_valid)
);

// File: tb/dram_mux_ctrl_test.sv
`timescale 1ns/1ps
module dram_mux_ctrl_test;
    localparam int T_RCD = 3, T_CAS = 2, T_RP = 2;

    typedef struct packed {
        logic [1:0] mode;
        logic       wr;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic [7:0] exp0;
        logic [2:0] nrd;
        logic [1:0] nact;
        logic [2:0] ncas;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 1'b1, 8'h35, 8'hA1, 8'h00, 3'd0, 2'd1, 3'd1},
        '{2'b00, 1'b0, 8'h35, 8'h00, 8'hA1, 3'd1, 2'd1, 3'd1},
        '{2'b01, 1'b1, 8'h42, 8'h10, 8'h00, 3'd0, 2'd1, 3'd4},
        '{2'b01, 1'b0, 8'h42, 8'h00, 8'h10, 3'd4, 2'd1, 3'd4},
        '{2'b00, 1'b0, 8'h40, 8'h00, 8'h12, 3'd1, 2'd1, 3'd1},
        '{2'b11, 1'b0, 8'h50, 8'h00, 8'h00, 3'd1, 2'd1, 3'd1},
        '{2'b10, 1'b1, 8'h71, 8'h5A, 8'h00, 3'd0, 2'd1, 3'd1},
        '{2'b10, 1'b1, 8'h7E, 8'h5B, 8'h00, 3'd0, 2'd0, 3'd1},
        '{2'b10, 1'b0, 8'h71, 8'h00, 8'h5A, 3'd1, 2'd0, 3'd1},
        '{2'b10, 1'b0, 8'h8E, 8'h00, 8'h00, 3'd1, 2'd1, 3'd1},
        '{2'b00, 1'b0, 8'h7E, 8'h00, 8'h5B, 3'd1, 2'd1, 3'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0, ref_done = 1'b0;
    logic [1:0] req_mode = '0;
    logic [7:0] req_addr = '0, req_wdata = '0;
    logic req_ready, rd_valid, ref_gnt, ras_n, cas_n, we_n;
    logic [7:0] rd_data;
    logic [3:0] dram_addr;
    wire  [7:0] dq;

    int checks = 0, failures = 0, cyc = 0;

    always #2 clk = ~clk;

    dram_mux_ctrl #(.ROW_W(4), .COL_W(4), .DATA_W(8), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .ref_done(ref_done), .dram_addr(dram_addr), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
        .dram_we_n(we_n), .dram_dq(dq)
    );

    // Behavioural device: row latched on row strobe fall, data on column strobe.
    logic [7:0] mem [256];
    logic [3:0] row_lat = '0;
    logic       m_prev_ras = 1'b1;
    initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    always @(posedge clk) begin
        if (m_prev_ras && !ras_n) row_lat <= dram_addr;
        if (!cas_n && !we_n) mem[{row_lat, dram_addr}] <= dq;
        m_prev_ras <= ras_n;
    end
    assign dq = (!cas_n && we_n) ? mem[{row_lat, dram_addr}] : 8'hzz;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Port monitor sampled on the falling clock edge.
    int act_cnt = 0, cas_cnt = 0, rd_n = 0;
    int rise_t = 0, fall_t = 0, cas_fall_t = 0;
    bit first_cas = 1'b0, prev_ras = 1'b1, prev_cas = 1'b1;
    logic [3:0] last_row = '0;
    logic [3:0] cols [256];
    logic [7:0] rd_buf [256];
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                act_cnt++; last_row = dram_addr; fall_t = cyc; first_cas = 1'b1;
                check(cyc - rise_t >= T_RP, "R9 precharge gap", cyc - rise_t, T_RP);
            end
            if (!prev_ras && ras_n) rise_t = cyc;
            if (prev_cas && !cas_n) begin
                cols[cas_cnt % 256] = dram_addr; cas_cnt++; cas_fall_t = cyc;
                check(!ras_n, "R1 cas inside ras", ras_n, 0);
                if (first_cas) check(cyc - fall_t == T_RCD, "R2 ras-to-cas", cyc - fall_t, T_RCD);
                first_cas = 1'b0;
            end
            if (!prev_cas && cas_n)
                check(cyc - cas_fall_t == T_CAS, "R2 cas width", cyc - cas_fall_t, T_CAS);
            if (rd_valid) begin
                check(!prev_cas && cas_n, "R7 rd_valid timing", prev_cas, 0);
                rd_buf[rd_n % 256] = rd_data; rd_n++;
            end
            if (ref_gnt && !ras_n) check(1'b0, "R8 grant with row open", ras_n, 1);
        end
        prev_ras = ras_n;
        prev_cas = cas_n;
    end

    // Present one request from a falling edge and hold it until accepted.
    task automatic send(input logic [1:0] m, input logic w, input logic [7:0] a, input logic [7:0] d);
        req_mode = m; req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(ras_n && cas_n && we_n, "R10 strobes high", {ras_n, cas_n, we_n}, 3'b111);
        check(!ref_gnt && !rd_valid, "R10 grant/valid low", {ref_gnt, rd_valid}, 0);
        check(req_ready, "R10 ready", req_ready, 1);

        // Vector table: R1 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            int a0, c0, r0;
            a0 = act_cnt; c0 = cas_cnt; r0 = rd_n;
            send(VEC[v].mode, VEC[v].wr, VEC[v].addr, VEC[v].wdata);
            repeat (30) @(negedge clk);
            check(act_cnt - a0 == VEC[v].nact, $sformatf("R3/R5 activations v%0d", v), act_cnt - a0, VEC[v].nact);
            check(cas_cnt - c0 == VEC[v].ncas, $sformatf("R3/R4 column cycles v%0d", v), cas_cnt - c0, VEC[v].ncas);
            check(rd_n - r0 == VEC[v].nrd, $sformatf("R7 read pulses v%0d", v), rd_n - r0, VEC[v].nrd);
            if (VEC[v].nact != 0)
                check(last_row == VEC[v].addr[7:4], $sformatf("R1 row v%0d", v), last_row, VEC[v].addr[7:4]);
            for (int k = 0; k < int'(VEC[v].ncas); k++) begin
                logic [3:0] ec;
                logic [1:0] lo;
                lo = VEC[v].addr[1:0] + 2'(k);
                ec = {VEC[v].addr[3:2], lo};
                check(cols[(c0 + k) % 256] == ec, $sformatf("R1/R4 column v%0d beat%0d", v, k), cols[(c0 + k) % 256], ec);
            end
            for (int k = 0; k < int'(VEC[v].nrd); k++)
                check(rd_buf[(r0 + k) % 256] == VEC[v].exp0 + 8'(k), $sformatf("R4/R6 read data v%0d word%0d", v, k),
                      rd_buf[(r0 + k) % 256], VEC[v].exp0 + 8'(k));
        end

        // R8: refresh arriving with a page open
        send(2'b10, 1'b0, 8'h71, 8'h00);
        repeat (12) @(negedge clk);
        check(!ras_n, "R5 page left open", ras_n, 0);
        ref_req = 1'b1;
        for (int i = 0; i < 20 && !ref_gnt; i++) @(negedge clk);
        check(ref_gnt, "R8 grant given", ref_gnt, 1);
        check(ras_n && cas_n, "R8 row closed at grant", {ras_n, cas_n}, 2'b11);
        req_mode = 2'b00; req_write = 1'b0; req_addr = 8'h35; req_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            check(ref_gnt && !req_ready, "R8 grant held, host blocked", {ref_gnt, req_ready}, 2'b10);
        end
        req_valid = 1'b0;
        @(negedge clk);
        ref_done = 1'b1; ref_req = 1'b0;
        @(negedge clk);
        ref_done = 1'b0;
        check(!ref_gnt, "R8 grant released", ref_gnt, 0);
        begin
            int r0;
            r0 = rd_n;
            send(2'b00, 1'b0, 8'h35, 8'h00);
            repeat (20) @(negedge clk);
            check(rd_n - r0 == 1 && rd_buf[r0 % 256] == 8'hA1, "R9/R7 access after refresh",
                  rd_buf[r0 % 256], 8'hA1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule